// File: doc/BRIEF.md
# Four-Switch Buck-Boost Gate Pattern Generator

This block drives the four gates of a single-inductor, four-switch buck-boost power stage. The stage has two half-bridges. The input-side leg performs step-down switching, and the output-side leg performs step-up switching. A free-running period counter sets the switching frequency. With the default of 400 counter clocks per period, an 88 MHz clock gives 220 kHz. Each period, a mode selector decides which leg switches and which leg is held static. A duty command sets the on-time of the high side in the switching leg.

The duty comes from one of two places. Normally it comes from an external tracking loop. In test mode it comes from a fixed open-loop register value. The choice between these two sources is captured only while the soft reset is held. Programmable turn-on and turn-off gaps separate the two gates of each leg. Duty, mode and gaps are all sampled at a period boundary. Soft reset, the global gate disable and the asynchronous reset each force every gate low.

Top module: `fsbb_pwm`

## Requirements
- R1: In step-down mode (`mode_i`=0), the output leg is static: `bst_hi_o`=1 and `bst_lo_o`=0. In step-up mode (`mode_i`=1), the input leg is static: `buck_hi_o`=1 and `buck_lo_o`=0.
- R2: In pass-through mode (`mode_i`=2), both high sides are on and both low sides are off. With `mode_i`=3, all four gates are off.
- R3: In the switching leg, counter phase c runs from 0 to PERIOD-1. The high side is on for dt_rise ≤ c < D. The low side is on for D+dt_fall ≤ c ≤ PERIOD-1. Each period therefore has D-dt_rise high-side cycles and PERIOD-D-dt_fall low-side cycles.
- R4: The high and low gates of one leg are never on in the same cycle.
- R5: The effective duty D is the selected command clamped to the range [2·dt_rise, PERIOD-2·dt_fall]. This keeps every on-pulse at least as long as its gap.
- R6: Duty, mode and gaps are sampled only on the last cycle of a period. A change made mid-period has no effect until the next period. After any reset, the first period is all-off.
- R7: The duty source is the 9-bit `ol_duty_i` when the open-loop select was 1 during the most recent soft reset, and `trk_duty_i` otherwise. Changing `ol_en_i` outside a soft reset has no effect.
- R8: While `soft_rst_i` is high, all gates go low from the next cycle, and the period counter restarts at 0.
- R9: While `gate_dis_i` is high, all gates go low from the next cycle.
- R10: While `rst_n` is low, all gates are low at once, without waiting for a clock.
- R11: The gaps are 3-bit values in counter clocks (0 to 7). The turn-on and turn-off gaps apply independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous soft reset; captures the open-loop select |
| gate_dis_i | input | 1 | Global gate disable |
| mode_i | input | 2 | 0 step-down, 1 step-up, 2 pass-through, 3 off |
| trk_duty_i | input | 9 | Duty command from the tracking loop |
| ol_duty_i | input | 9 | Open-loop duty value |
| ol_en_i | input | 1 | Open-loop select, captured during soft reset |
| dt_rise_i | input | 3 | Gap before a high side turns on |
| dt_fall_i | input | 3 | Gap after a high side turns off |
| buck_hi_o | output | 1 | Input leg high-side gate |
| buck_lo_o | output | 1 | Input leg low-side gate |
| bst_hi_o | output | 1 | Output leg high-side gate |
| bst_lo_o | output | 1 | Output leg low-side gate |

## Verification
The bench measures the on-cycles of every gate over a full period. It does this for each mode and for duty values beyond both clamp limits. A wrong gap or clamp shows up as a wrong count, and a shoot-through shows up as an overlap count. The bench also changes the mode mid-period. A design that loaded immediately would switch the static leg early. The open-loop select is toggled with and without a soft reset, which catches a design that follows the select live. Gate behaviour is checked in the first period after reset, under disable, and at an asynchronous reset taken mid-run. This catches a design that runs the previous pattern or waits for a clock.

// File: rtl/fsbb_pkg.sv
package fsbb_pkg;

  typedef enum logic [1:0] {
    MODE_BUCK  = 2'd0,
    MODE_BOOST = 2'd1,
    MODE_PASS  = 2'd2,
    MODE_IDLE  = 2'd3
  } conv_mode_e;

  typedef enum logic [1:0] {
    ROLE_OFF = 2'd0,
    ROLE_SW  = 2'd1,
    ROLE_HI  = 2'd2
  } leg_role_e;

  // Effective duty: lower limit keeps the high pulse >= rise gap,
  // upper limit keeps the low pulse >= fall gap.
  function automatic int clamp_duty(int d, int dtn, int dtf, int period);
    int lo;
    int hi;
    lo = 2 * dtn;
    hi = period - 2 * dtf;
    if (d > hi) return hi;
    if (d < lo) return lo;
    return d;
  endfunction

  // Leg 0 = input (step-down) leg, leg 1 = output (step-up) leg.
  function automatic leg_role_e role_of(conv_mode_e m, int leg);
    case (m)
      MODE_BUCK:  return (leg == 0) ? ROLE_SW : ROLE_HI;
      MODE_BOOST: return (leg == 1) ? ROLE_SW : ROLE_HI;
      MODE_PASS:  return ROLE_HI;
      default:    return ROLE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/fsbb_period_ctr.sv
module fsbb_period_ctr #(
  parameter int PERIOD = 400,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_end_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  assign period_end_o = (cnt_o == LAST) && !soft_rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_o <= '0;
    else if (soft_rst_i || cnt_o == LAST) cnt_o <= '0;
    else                                cnt_o <= cnt_o + 1'b1;
  end

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> (cnt_o == '0));

  p_softrst_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (cnt_o == '0));

endmodule

// File: rtl/fsbb_cfg_latch.sv
module fsbb_cfg_latch
  import fsbb_pkg::*;
#(
  parameter int PERIOD = 400,
  parameter int DUTY_W = 9,
  parameter int DT_W   = 3,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              load_i,
  input  logic [1:0]        mode_i,
  input  logic [DUTY_W-1:0] trk_duty_i,
  input  logic [DUTY_W-1:0] ol_duty_i,
  input  logic              ol_en_i,
  input  logic [DT_W-1:0]   dt_rise_i,
  input  logic [DT_W-1:0]   dt_fall_i,
  output conv_mode_e        mode_q,
  output logic [CNT_W-1:0]  duty_q,
  output logic [DT_W-1:0]   dtn_q,
  output logic [DT_W-1:0]   dtf_q,
  output logic              ol_act_q
);
  localparam int DT_RST   = 3;
  localparam int DUTY_RST = 255;

  logic [DUTY_W-1:0] duty_sel;
  int                duty_eff;

  assign duty_sel = ol_act_q ? ol_duty_i : trk_duty_i;
  assign duty_eff = clamp_duty(int'(duty_sel), int'(dt_rise_i), int'(dt_fall_i), PERIOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ol_act_q <= 1'b0;
    else if (soft_rst_i) ol_act_q <= ol_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      duty_q <= CNT_W'(clamp_duty(DUTY_RST, DT_RST, DT_RST, PERIOD));
      dtn_q  <= DT_W'(DT_RST);
      dtf_q  <= DT_W'(DT_RST);
    end else if (soft_rst_i) begin
      mode_q <= MODE_IDLE;
    end else if (load_i) begin
      mode_q <= conv_mode_e'(mode_i);
      duty_q <= CNT_W'(duty_eff);
      dtn_q  <= dt_rise_i;
      dtf_q  <= dt_fall_i;
    end
  end

  p_hold_midperiod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !soft_rst_i) |=> ($stable(duty_q) && $stable(mode_q) &&
                                  $stable(dtn_q) && $stable(dtf_q)));

  p_duty_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(duty_q) >= 2 * int'(dtn_q)) && (int'(duty_q) <= PERIOD - 2 * int'(dtf_q)));

  p_ol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst_i |=> $stable(ol_act_q));

endmodule

// File: rtl/fsbb_leg.sv
module fsbb_leg
  import fsbb_pkg::*;
#(
  parameter int PERIOD = 400,
  parameter int DT_W   = 3,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_i,
  input  leg_role_e        role_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dtn_i,
  input  logic [DT_W-1:0]  dtf_i,
  output logic             hs_o,
  output logic             ls_o
);
  logic hs_n, ls_n, sw_q;

  always_comb begin
    hs_n = 1'b0;
    ls_n = 1'b0;
    case (role_i)
      ROLE_SW: begin
        hs_n = (int'(cnt_i) >= int'(dtn_i)) && (int'(cnt_i) < int'(duty_i));
        ls_n = int'(cnt_i) >= int'(duty_i) + int'(dtf_i);
      end
      ROLE_HI: hs_n = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
      sw_q <= 1'b0;
    end else if (kill_i) begin
      hs_o <= 1'b0;
      ls_o <= 1'b0;
      sw_q <= 1'b0;
    end else begin
      hs_o <= hs_n;
      ls_o <= ls_n;
      sw_q <= (role_i == ROLE_SW);
    end
  end

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_o && ls_o));

  p_fall_gap_r11: assert property (@(posedge clk) disable iff (!rst_n || kill_i)
    (sw_q && $past(sw_q) && $fell(hs_o) && dtf_i >= 2) |=> !ls_o);

  p_rise_gap_r11: assert property (@(posedge clk) disable iff (!rst_n || kill_i)
    (sw_q && $past(sw_q) && $fell(ls_o) && dtn_i >= 2) |=> !hs_o);

endmodule

// File: rtl/fsbb_pwm.sv
module fsbb_pwm
  import fsbb_pkg::*;
#(
  parameter int PERIOD = 400,
  parameter int DUTY_W = 9,
  parameter int DT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              gate_dis_i,
  input  logic [1:0]        mode_i,
  input  logic [DUTY_W-1:0] trk_duty_i,
  input  logic [DUTY_W-1:0] ol_duty_i,
  input  logic              ol_en_i,
  input  logic [DT_W-1:0]   dt_rise_i,
  input  logic [DT_W-1:0]   dt_fall_i,
  output logic              buck_hi_o,
  output logic              buck_lo_o,
  output logic              bst_hi_o,
  output logic              bst_lo_o
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam int NLEG  = 2;

  logic [CNT_W-1:0] cnt;
  logic             period_end;
  logic             kill;
  conv_mode_e       mode_q;
  logic [CNT_W-1:0] duty_q;
  logic [DT_W-1:0]  dtn_q, dtf_q;
  logic             ol_act;
  logic [NLEG-1:0]  hs, ls;

  assign kill = soft_rst_i | gate_dis_i;

  fsbb_period_ctr #(.PERIOD(PERIOD)) u_ctr (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .cnt_o(cnt), .period_end_o(period_end)
  );

  fsbb_cfg_latch #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .DT_W(DT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .load_i(period_end),
    .mode_i(mode_i), .trk_duty_i(trk_duty_i), .ol_duty_i(ol_duty_i),
    .ol_en_i(ol_en_i), .dt_rise_i(dt_rise_i), .dt_fall_i(dt_fall_i),
    .mode_q(mode_q), .duty_q(duty_q), .dtn_q(dtn_q), .dtf_q(dtf_q),
    .ol_act_q(ol_act)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    leg_role_e role;
    assign role = role_of(mode_q, g);
    fsbb_leg #(.PERIOD(PERIOD), .DT_W(DT_W)) u_leg (
      .clk(clk), .rst_n(rst_n), .kill_i(kill), .role_i(role),
      .cnt_i(cnt), .duty_i(duty_q), .dtn_i(dtn_q), .dtf_i(dtf_q),
      .hs_o(hs[g]), .ls_o(ls[g])
    );
  end

  assign buck_hi_o = hs[0];
  assign buck_lo_o = ls[0];
  assign bst_hi_o  = hs[1];
  assign bst_lo_o  = ls[1];

  p_disable_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_dis_i |=> !(buck_hi_o || buck_lo_o || bst_hi_o || bst_lo_o));

  p_softrst_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> !(buck_hi_o || buck_lo_o || bst_hi_o || bst_lo_o));

  p_static_leg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_lo_o || buck_lo_o) |-> !(bst_lo_o && buck_lo_o));

  always @(negedge clk) begin
    if (!rst_n) begin
      p_async_off_r10: assert (!(buck_hi_o || buck_lo_o || bst_hi_o || bst_lo_o));
    end
  end

endmodule

// File: tb/sim_fsbb_pwm.sv
module sim_fsbb_pwm;
  localparam int P = 400;
  localparam int NV = 9;
  localparam int V_MODE [NV] = '{0, 1, 2, 3, 0, 0, 1, 0, 1};
  localparam int V_DUTY [NV] = '{200, 150, 200, 200, 0, 511, 7, 300, 400};
  localparam int V_DTN  [NV] = '{3, 2, 3, 3, 3, 3, 0, 7, 7};
  localparam int V_DTF  [NV] = '{3, 5, 3, 3, 4, 4, 0, 1, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, gate_dis = 1'b0, ol_en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [8:0] trk_duty = 9'd200, ol_duty = 9'd100;
  logic [2:0] dtn = 3'd3, dtf = 3'd3;
  logic buck_hi, buck_lo, bst_hi, bst_lo;

  int n_chk = 0, n_fail = 0, wd = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsbb_pwm u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .gate_dis_i(gate_dis),
    .mode_i(mode), .trk_duty_i(trk_duty), .ol_duty_i(ol_duty), .ol_en_i(ol_en),
    .dt_rise_i(dtn), .dt_fall_i(dtf),
    .buck_hi_o(buck_hi), .buck_lo_o(buck_lo), .bst_hi_o(bst_hi), .bst_lo_o(bst_lo)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", wd);
      finish_run();
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Effective duty restated: limit from above first, then from below.
  function automatic int eff_duty(int d, int rise, int fall);
    int top;
    int r;
    top = P - fall - fall;
    r = (d < top) ? d : top;
    if (r < rise + rise) r = rise + rise;
    return r;
  endfunction

  // 0 = off, 1 = switching, 2 = static high; leg 0 input side, leg 1 output side
  function automatic int leg_kind(int m, int leg);
    if (m == 3) return 0;
    if (m == 2) return 2;
    return (m == leg) ? 1 : 2;
  endfunction

  task automatic measure(int m, int d, int rise, int fall, string tag);
    int c_bh, c_bl, c_sh, c_sl, c_ov;
    int de, k, eh, el;
    c_bh = 0; c_bl = 0; c_sh = 0; c_sl = 0; c_ov = 0;
    for (int i = 0; i < P; i++) begin
      @(posedge clk); #2;
      c_bh += int'(buck_hi); c_bl += int'(buck_lo);
      c_sh += int'(bst_hi);  c_sl += int'(bst_lo);
      if ((buck_hi && buck_lo) || (bst_hi && bst_lo)) c_ov++;
    end
    de = eff_duty(d, rise, fall);
    for (int leg = 0; leg < 2; leg++) begin
      k = leg_kind(m, leg);
      eh = (k == 1) ? de - rise : ((k == 2) ? P : 0);
      el = (k == 1) ? P - de - fall : 0;
      if (k == 1) begin
        check(tag, (leg == 0) ? c_bh : c_sh, eh);
        check(tag, (leg == 0) ? c_bl : c_sl, el);
      end else if (m >= 2) begin
        check("R2", (leg == 0) ? c_bh : c_sh, eh);
        check("R2", (leg == 0) ? c_bl : c_sl, el);
      end else begin
        check("R1", (leg == 0) ? c_bh : c_sh, eh);
        check("R1", (leg == 0) ? c_bl : c_sl, el);
      end
    end
    check("R4 overlap", c_ov, 0);
  endtask

  function automatic string vec_tag(int i);
    case (i)
      4, 5, 8: return "R5";
      7:       return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic all_low(string req);
    check(req, int'({buck_hi, buck_lo, bst_hi, bst_lo}), 0);
  endtask

  task automatic pulse_soft();
    @(posedge clk); #1 soft_rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 all_low("R8 soft reset");
    @(negedge clk) soft_rst = 1'b0;
  endtask

  initial begin
    // Reset state (R10) and first period after reset (R6)
    repeat (3) @(posedge clk);
    #2 all_low("R10 during reset");
    @(negedge clk) rst_n = 1'b1;
    repeat (P) @(posedge clk);
    #2 all_low("R6 first period off");
    @(posedge clk); #2;
    check("R6 load at boundary bst_hi", int'(bst_hi), 1);
    check("R6 load at boundary buck_hi", int'(buck_hi), 0);
    mode = 2'd1;
    repeat (P - 10) @(posedge clk);
    #2;
    check("R6 mid-period change bst_lo", int'(bst_lo), 0);
    check("R6 mid-period change bst_hi", int'(bst_hi), 1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1;
      mode = 2'(V_MODE[i]); trk_duty = 9'(V_DUTY[i]);
      dtn = 3'(V_DTN[i]); dtf = 3'(V_DTF[i]);
      repeat (2 * P) @(posedge clk);
      measure(V_MODE[i], V_DUTY[i], V_DTN[i], V_DTF[i], vec_tag(i));
    end

    // Global disable (R9)
    @(posedge clk); #1;
    mode = 2'd2;
    repeat (2 * P) @(posedge clk);
    #1 gate_dis = 1'b1;
    @(posedge clk); #2 all_low("R9 disable next cycle");
    repeat (P / 2) @(posedge clk);
    #2 all_low("R9 disable held");
    @(negedge clk) gate_dis = 1'b0;

    // Open-loop source selection (R7)
    mode = 2'd0; dtn = 3'd3; dtf = 3'd3; trk_duty = 9'd200; ol_duty = 9'd100;
    ol_en = 1'b1;
    repeat (2 * P) @(posedge clk);
    measure(0, 200, 3, 3, "R7 select without soft reset");
    pulse_soft();
    repeat (2 * P) @(posedge clk);
    measure(0, 100, 3, 3, "R7 open loop active");
    ol_en = 1'b0;
    repeat (2 * P) @(posedge clk);
    measure(0, 100, 3, 3, "R7 select cleared without soft reset");
    pulse_soft();
    repeat (2 * P) @(posedge clk);
    measure(0, 200, 3, 3, "R7 tracking restored");

    // Asynchronous reset mid-run (R10)
    mode = 2'd2;
    repeat (2 * P) @(posedge clk);
    #2 check("R10 pre-reset bst_hi", int'(bst_hi), 1);
    #1 rst_n = 1'b0;
    #1 all_low("R10 async reset");
    @(negedge clk) rst_n = 1'b1;

    finish_run();
  end
endmodule